// File: doc/BRIEF.md
# Frequency Synthesizer Dividers and Phase-Frequency Comparator

This block is the digital core of a frequency synthesizer loop. A fixed reference clock is divided by a programmable 6-bit reference modulus. The clock returned from an external voltage-controlled oscillator is divided by a second, independent 6-bit feedback modulus. A phase-frequency comparator then compares the two divided signals. It produces a correction for an off-chip loop filter, and the loop settles where the oscillator runs at feedback modulus / reference modulus times the reference frequency.

The correction output is a three-state pin, modelled here by three signals. A drive enable and a drive value together ask the oscillator to speed up (driven high) or slow down (driven low). When no correction is needed the pin is left undriven. At lock the divided edges arrive together, and the pin is driven to a midpoint level for a single reference cycle once every comparison period, shown by a midpoint strobe. A small register port sets both moduli. A new modulus reaches a divider only at that divider's terminal count.

All comparison logic runs in the reference clock domain. The divided feedback crosses into it through a synchronizer, and the divided reference passes through a matched delay of the same length, so that edges arriving together at the dividers also arrive together at the comparator.

Top module: `fsyn_loop_core`

## Requirements
- R1: `ref_div_o` pulses high for one reference cycle, once every r reference cycles, where r is the programmed reference modulus in the range 1 to 63.
- R2: A modulus value of 0 divides by 64, for both the reference and the feedback divider.
- R3: `fb_div_o` changes level once every v oscillator cycles, where v is the programmed feedback modulus.
- R4: A modulus written with `cfg_we_i` takes effect only at the divider's next terminal count. The period in progress completes at its old length, and no period of any other length appears.
- R5: When the divided feedback matches the divided reference in frequency and phase, `drv_en_o` stays 0. `mid_o` is 1 for one cycle at a spacing of exactly r reference cycles, and it is held high continuously when r is 1.
- R6: When the divided feedback is slower than the divided reference, the output drives high (`drv_en_o`=1, `drv_val_o`=1) for part of each period. It never drives low (`drv_en_o`=1, `drv_val_o`=0), and a drive-high state is never followed directly by a drive-low state.
- R7: When the divided feedback is faster than the divided reference, the output drives low and never drives high. A drive-low state is never followed directly by a drive-high state.
- R8: `mid_o` and `drv_en_o` are never 1 in the same cycle.
- R9: While `rst_ni` is low, and after it rises until the first divided edge reaches the comparator, `drv_en_o`, `mid_o` and `ref_div_o` are 0. Both moduli reset to 0, which means divide by 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Fixed reference clock; clocks the register port and the comparator |
| vco_clk_i | input | 1 | Oscillator feedback clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| cfg_we_i | input | 1 | Write strobe for both moduli (reference domain) |
| cfg_r_i | input | 6 | Reference modulus to write (0 means 64) |
| cfg_v_i | input | 6 | Feedback modulus to write (0 means 64) |
| drv_en_o | output | 1 | Correction pin driven when 1 |
| drv_val_o | output | 1 | Driven level: 1 speeds the oscillator up, 0 slows it down |
| mid_o | output | 1 | Midpoint drive strobe at lock |
| ref_div_o | output | 1 | Divided reference pulse |
| fb_div_o | output | 1 | Divided feedback, one level change per period |

## Verification
The comparator is run with three kinds of modulus pairs. Equal moduli give matched frequency and phase, which must produce only midpoint strobes at the comparison period. A feedback modulus larger than the reference modulus must produce only high drive, and a smaller one only low drive. These three cases separate a correct comparator from one that swaps directions, leaks drive at lock, or drops the midpoint strobe. Random modulus pairs, with zero mixed in, cover the divide-by-64 encoding. Directed cases cover reset, the idle interval before the first edge, and a modulus write in the middle of a period, which tells a reload at terminal count apart from an immediate one.

// File: rtl/fsyn_pkg.sv
package fsyn_pkg;
  localparam int unsigned MOD_W       = 6;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned N_PATHS     = 2;  // 0: reference, 1: feedback

  typedef struct packed {
    logic up;
    logic dn;
  } pfd_flags_t;
endpackage

// File: rtl/fsyn_div.sv
module fsyn_div #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] mod_i,
  output logic         tick_o,
  output logic         tgl_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] term_q;
  logic         at_term;

  assign at_term = (cnt_q == term_q);

  // term = modulus-1 in W bits, so modulus 0 wraps to all-ones (2**W)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      term_q <= '1;
      tick_o <= 1'b0;
      tgl_o  <= 1'b0;
    end else begin
      tick_o <= at_term;
      if (at_term) begin
        cnt_q  <= '0;
        term_q <= mod_i - W'(1);
        tgl_o  <= ~tgl_o;
      end else begin
        cnt_q  <= cnt_q + W'(1);
      end
    end
  end
endmodule

// File: rtl/fsyn_edge_sync.sv
module fsyn_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic ev_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], tgl_i};
  end

  assign ev_o = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/fsyn_pfd.sv
module fsyn_pfd
  import fsyn_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_ev_i,
  input  logic fb_ev_i,
  output logic drv_en_o,
  output logic drv_val_o,
  output logic mid_o
);
  pfd_flags_t flag_q, flag_d;

  // both set: clear together, but keep an edge landing in the clear cycle
  always_comb begin
    if (flag_q.up && flag_q.dn) begin
      flag_d.up = ref_ev_i;
      flag_d.dn = fb_ev_i;
    end else begin
      flag_d.up = flag_q.up | ref_ev_i;
      flag_d.dn = flag_q.dn | fb_ev_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  assign drv_en_o  = flag_q.up ^ flag_q.dn;
  assign drv_val_o = flag_q.up & ~flag_q.dn;
  assign mid_o     = flag_q.up & flag_q.dn;
endmodule

// File: rtl/fsyn_loop_core.sv
module fsyn_loop_core
  import fsyn_pkg::*;
(
  input  logic             ref_clk_i,
  input  logic             vco_clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [MOD_W-1:0] cfg_r_i,
  input  logic [MOD_W-1:0] cfg_v_i,
  output logic             drv_en_o,
  output logic             drv_val_o,
  output logic             mid_o,
  output logic             ref_div_o,
  output logic             fb_div_o
);
  logic [MOD_W-1:0]   mod_r_q, mod_v_q;
  logic               ref_tick, fb_tick;
  logic [N_PATHS-1:0] tgl_vec, ev_vec;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_r_q <= '0;
      mod_v_q <= '0;
    end else if (cfg_we_i) begin
      mod_r_q <= cfg_r_i;
      mod_v_q <= cfg_v_i;
    end
  end

  fsyn_div #(.W(MOD_W)) u_ref_div (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .mod_i  (mod_r_q),
    .tick_o (ref_tick),
    .tgl_o  (tgl_vec[0])
  );

  // mod_v_q is quasi-static; sampled only at the feedback terminal count
  fsyn_div #(.W(MOD_W)) u_fb_div (
    .clk_i  (vco_clk_i),
    .rst_ni (rst_ni),
    .mod_i  (mod_v_q),
    .tick_o (fb_tick),
    .tgl_o  (tgl_vec[1])
  );

  // identical stages on both paths keep the comparator latency matched
  for (genvar p = 0; p < N_PATHS; p++) begin : g_path
    fsyn_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (ref_clk_i),
      .rst_ni (rst_ni),
      .tgl_i  (tgl_vec[p]),
      .ev_o   (ev_vec[p])
    );
  end

  fsyn_pfd u_pfd (
    .clk_i     (ref_clk_i),
    .rst_ni    (rst_ni),
    .ref_ev_i  (ev_vec[0]),
    .fb_ev_i   (ev_vec[1]),
    .drv_en_o  (drv_en_o),
    .drv_val_o (drv_val_o),
    .mid_o     (mid_o)
  );

  assign ref_div_o = ref_tick;
  assign fb_div_o  = tgl_vec[1];

  logic unused_fb_tick;
  assign unused_fb_tick = fb_tick;
endmodule

// File: rtl/fsyn_loop_chk.sv
module fsyn_loop_chk (
  input logic ref_clk_i,
  input logic rst_ni,
  input logic drv_en_o,
  input logic drv_val_o,
  input logic mid_o,
  input logic ref_div_o
);
  logic [6:0] gap_q;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni)            gap_q <= '0;
    else if (ref_div_o)     gap_q <= '0;
    else if (gap_q != 7'h7f) gap_q <= gap_q + 7'd1;
  end

  // R2: no reference period longer than 64 cycles
  a_r2_period_max: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    gap_q <= 7'd64);

  a_r8_mid_undriven: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    mid_o |-> !drv_en_o);

  a_r6_up_not_to_down: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (drv_en_o && drv_val_o) |=> !(drv_en_o && !drv_val_o));

  a_r7_down_not_to_up: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (drv_en_o && !drv_val_o) |=> !(drv_en_o && drv_val_o));
endmodule

bind fsyn_loop_core fsyn_loop_chk u_chk (
  .ref_clk_i (ref_clk_i),
  .rst_ni    (rst_ni),
  .drv_en_o  (drv_en_o),
  .drv_val_o (drv_val_o),
  .mid_o     (mid_o),
  .ref_div_o (ref_div_o)
);

// File: tb/tb_fsyn_loop_core.sv
`timescale 1ns/1ps
module tb_fsyn_loop_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [5:0] cfg_r = '0, cfg_v = '0;
  logic       drv_en, drv_val, mid, ref_div, fb_div;

  always #5 clk = ~clk;

  fsyn_loop_core dut (
    .ref_clk_i (clk),
    .vco_clk_i (clk),
    .rst_ni    (rst_n),
    .cfg_we_i  (cfg_we),
    .cfg_r_i   (cfg_r),
    .cfg_v_i   (cfg_v),
    .drv_en_o  (drv_en),
    .drv_val_o (drv_val),
    .mid_o     (mid),
    .ref_div_o (ref_div),
    .fb_div_o  (fb_div)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // monitor state
  bit mon_on = 0;
  int r_exp = 1, v_exp = 1, cyc = 0;
  int ref_last, fb_last, mid_last;
  bit ref_seen, fb_seen, mid_seen, fb_prev;
  int ref_n, ref_bad, fb_n, fb_bad, mid_n, mid_bad, up_n, dn_n, mid_en_n;

  function automatic int eff(input int m);
    return (m == 0) ? 64 : m;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    ref_seen = 0; fb_seen = 0; mid_seen = 0; fb_prev = fb_div;
    ref_n = 0; ref_bad = 0; fb_n = 0; fb_bad = 0;
    mid_n = 0; mid_bad = 0; up_n = 0; dn_n = 0; mid_en_n = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (ref_div) begin
        if (ref_seen) begin ref_n++; if (cyc - ref_last != r_exp) ref_bad++; end
        ref_seen = 1; ref_last = cyc;
      end
      if (fb_div != fb_prev) begin
        if (fb_seen) begin fb_n++; if (cyc - fb_last != v_exp) fb_bad++; end
        fb_seen = 1; fb_last = cyc;
      end
      fb_prev = fb_div;
      if (mid) begin
        if (mid_seen && (cyc - mid_last != r_exp)) mid_bad++;
        mid_seen = 1; mid_last = cyc; mid_n++;
        if (drv_en) mid_en_n++;
      end
      if (drv_en && drv_val)  up_n++;
      if (drv_en && !drv_val) dn_n++;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_cfg(input int r, input int v);
    @(negedge clk);
    cfg_r = 6'(r); cfg_v = 6'(v); cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_case(input int r, input int v);
    int re, ve, n;
    re = eff(r); ve = eff(v);
    n = 6 * ((re > ve) ? re : ve) + 40;
    do_reset();
    write_cfg(r, v);
    repeat (150) @(negedge clk);
    r_exp = re; v_exp = ve;
    clear_stats();
    mon_on = 1;
    repeat (n) @(negedge clk);
    mon_on = 0;
    // R1 / R2: reference period
    chk(ref_bad == 0 && ref_n > 0, (r == 0) ? "R2 ref div 64" : "R1 ref period", ref_bad, 0);
    // R3 / R2: feedback period
    chk(fb_bad == 0 && fb_n > 0, (v == 0) ? "R2 fb div 64" : "R3 fb period", fb_bad, 0);
    chk(mid_en_n == 0, "R8 mid with drive", mid_en_n, 0);
    if (re == ve) begin
      chk(up_n + dn_n == 0, "R5 lock undriven", up_n + dn_n, 0);
      chk(mid_bad == 0 && mid_n > 0, "R5 mid spacing", mid_bad, 0);
    end else if (ve > re) begin
      chk(dn_n == 0, "R6 no low drive", dn_n, 0);
      chk(up_n > 0, "R6 high drive seen", up_n, 1);
    end else begin
      chk(up_n == 0, "R7 no high drive", up_n, 0);
      chk(dn_n > 0, "R7 low drive seen", dn_n, 1);
    end
  endtask

  task automatic reset_case();
    int bad;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!drv_en && !mid && !ref_div, "R9 in reset", {drv_en, mid, ref_div}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (drv_en || mid || ref_div) bad++;
    end
    chk(bad == 0, "R9 idle before first edge", bad, 0);
    // R9: reset moduli mean 64, so next pulse at 64 cycles after reset
    bad = 0;
    for (int i = 0; i < 10 && !ref_div; i++) @(negedge clk);
    chk(ref_div == 1'b1, "R9 default modulus 64", ref_div, 1);
  endtask

  task automatic reload_case();
    int last, gap, n5, n9, other, order_bad;
    bit seen, got9;
    do_reset();
    write_cfg(5, 5);
    repeat (150) @(negedge clk);
    seen = 0; got9 = 0; n5 = 0; n9 = 0; other = 0; order_bad = 0; last = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (ref_div) begin
        if (seen) begin
          gap = i - last;
          if (gap == 5) begin n5++; if (got9) order_bad++; end
          else if (gap == 9) begin n9++; got9 = 1; end
          else other++;
        end
        seen = 1; last = i;
      end
      if (i == 42) begin cfg_r = 6'd9; cfg_v = 6'd9; cfg_we = 1'b1; end
      else cfg_we = 1'b0;
    end
    chk(other == 0, "R4 no odd period", other, 0);
    chk(order_bad == 0, "R4 old then new", order_bad, 0);
    chk(n9 >= 10 && n5 >= 5, "R4 both periods seen", n9, 10);
  endtask

  initial begin
    int r, v, s;
    s = $urandom(32'd5077);
    reset_case();
    reload_case();
    run_case(4, 4);
    run_case(0, 0);
    run_case(1, 1);
    run_case(3, 7);
    run_case(7, 3);
    run_case(0, 5);
    run_case(63, 0);
    for (int k = 0; k < 14; k++) begin
      r = ($urandom % 6 == 0) ? 0 : 1 + ($urandom % 12);
      v = ($urandom % 6 == 0) ? 0 : 1 + ($urandom % 12);
      if (k % 4 == 0) v = r;
      run_case(r, v);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule